// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a 12-bit narrow port A and a 24-bit wide port B. Port B is built from two 12-bit halves, B1 (low half) and B2 (high half). In the A-to-B direction, two narrow words taken from A in successive cycles are lined up and presented together as one wide word. The B1 half sits behind a two-stage pipeline and the B2 half behind a single register.

In the B-to-A direction, each half of B is captured in its own register. A registered select chooses which captured half drives A. Every data register loads on the rising clock edge only while its own active-low enable is low.

The output enables for A and B are active low and pass through registers, as does the select. A change of bus direction therefore takes effect only at a clock edge. Each three-state pad is modelled as a data output plus a drive flag. A synchronous active-high reset gives the drive state a defined value before any output enable has been sampled.

Top module: `bus_exchanger`

## Requirements
- R1: A data register whose active-low enable is high at a rising edge keeps its value, so the outputs fed from it do not change.
- R2: The A-to-B1 path has two stages. With `a_b1s1_en_n` low, stage 1 loads `a_in`. With `a_b1s2_en_n` low, stage 2 loads the old stage-1 value. `b1_out` shows stage 2.
- R3: The A-to-B2 path is one register that loads `a_in` while `a_b2_en_n` is low. `b2_out` shows it.
- R4: Two steps pair two narrow words. First, word W0 is applied with only the stage-1 enable low. Next, W1 is applied with the stage-2 and B2 enables low. After the second edge, {`b2_out`,`b1_out`} equals {W1,W0}.
- R5: The B1 capture register loads `b1_in` while `b1_a_en_n` is low. The B2 capture register loads `b2_in` while `b2_a_en_n` is low.
- R6: `sel` is registered at every edge. With the registered value at 0, A carries the B1 capture register. With it at 1, A carries the B2 capture register.
- R7: `oe_a_n` and `oe_b_n` are registered at every edge. Right after an edge, `a_drv` equals the inverse of the `oe_a_n` value sampled there. `b1_drv` and `b2_drv` both equal the inverse of the sampled `oe_b_n`.
- R8: A data output whose drive flag is low reads as zero.
- R9: A rising edge with `rst` high clears all data registers and the registered select. It also sets all drive flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | Data arriving on port A |
| a_out | output | 12 | Data driven onto port A |
| a_drv | output | 1 | Port A drive flag |
| b1_in | input | 12 | Data arriving on the low half of port B |
| b1_out | output | 12 | Data driven onto the low half of port B |
| b1_drv | output | 1 | Low-half drive flag |
| b2_in | input | 12 | Data arriving on the high half of port B |
| b2_out | output | 12 | Data driven onto the high half of port B |
| b2_drv | output | 1 | High-half drive flag |
| a_b1s1_en_n | input | 1 | Enable for stage 1 of the A-to-B1 path, active low |
| a_b1s2_en_n | input | 1 | Enable for stage 2 of the A-to-B1 path, active low |
| a_b2_en_n | input | 1 | Enable for the A-to-B2 register, active low |
| b1_a_en_n | input | 1 | Enable for the B1 capture register, active low |
| b2_a_en_n | input | 1 | Enable for the B2 capture register, active low |
| sel | input | 1 | Chooses the B half that drives A (0 selects B1, 1 selects B2) |
| oe_a_n | input | 1 | Port A output enable, active low |
| oe_b_n | input | 1 | Port B output enable, active low |

## Verification
Every result is due immediately after the edge that samples its cause. A load, a select change or an enable change shows on the outputs one ns after that edge. The B1 half is the exception: a word reaches it only after two enabled edges.

The bench applies all inputs one ns after an edge. It updates its own reference state at the next edge and compares all six outputs one ns later. This keeps every comparison in the cycle where the result becomes due. Directed sequences cover word pairing, holding, select switching, disabled outputs and reset. Random cycles mix all enables and controls.

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_drv,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_drv,
  input  logic         a_b1s1_en_n,
  input  logic         a_b1s2_en_n,
  input  logic         a_b2_en_n,
  input  logic         b1_a_en_n,
  input  logic         b2_a_en_n,
  input  logic         sel,
  input  logic         oe_a_n,
  input  logic         oe_b_n
);

  logic [W-1:0] stg1, stg2, hi_reg, cap1, cap2;
  logic         oea_q, oeb_q, sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1   <= '0;
      stg2   <= '0;
      hi_reg <= '0;
    end else begin
      if (!a_b1s1_en_n) stg1   <= a_in;
      if (!a_b1s2_en_n) stg2   <= stg1;
      if (!a_b2_en_n)   hi_reg <= a_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap1 <= '0;
      cap2 <= '0;
    end else begin
      if (!b1_a_en_n) cap1 <= b1_in;
      if (!b2_a_en_n) cap2 <= b2_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oea_q <= 1'b1;
      oeb_q <= 1'b1;
      sel_q <= 1'b0;
    end else begin
      oea_q <= oe_a_n;
      oeb_q <= oe_b_n;
      sel_q <= sel;
    end
  end

  assign a_drv  = ~oea_q;
  assign b1_drv = ~oeb_q;
  assign b2_drv = ~oeb_q;
  assign a_out  = a_drv  ? (sel_q ? cap2 : cap1) : '0;
  assign b1_out = b1_drv ? stg2   : '0;
  assign b2_out = b2_drv ? hi_reg : '0;

  AST_STG1_HOLD: assert property (@(posedge clk) disable iff (rst)
    a_b1s1_en_n |=> $stable(stg1)); // R1
  AST_CAP2_HOLD: assert property (@(posedge clk) disable iff (rst)
    b2_a_en_n |=> $stable(cap2)); // R1
  AST_STG2_LOAD: assert property (@(posedge clk) disable iff (rst)
    !a_b1s2_en_n |=> stg2 == $past(stg1)); // R2
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
    !a_b2_en_n |=> hi_reg == $past(a_in)); // R3
  AST_CAP1_LOAD: assert property (@(posedge clk) disable iff (rst)
    !b1_a_en_n |=> cap1 == $past(b1_in)); // R5
  AST_A_OE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> a_drv == !$past(oe_a_n)); // R7
  AST_B_OE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> b1_drv == !$past(oe_b_n)); // R7
  AST_RST_OFF: assert property (@(posedge clk)
    rst |=> !a_drv && !b1_drv && !b2_drv && a_out == '0); // R9

endmodule

// File: tb/bus_exchanger_test.sv
module bus_exchanger_test;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_drv, b1_drv, b2_drv;
  logic s1n, s2n, hin, c1n, c2n, sel, oean, oebn;

  logic [W-1:0] m_s1, m_s2, m_hi, m_c1, m_c2;
  logic m_oea, m_oeb, m_sel;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_exchanger #(.W(W)) uut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b1_in(b1_in), .b1_out(b1_out), .b1_drv(b1_drv),
    .b2_in(b2_in), .b2_out(b2_out), .b2_drv(b2_drv),
    .a_b1s1_en_n(s1n), .a_b1s2_en_n(s2n), .a_b2_en_n(hin),
    .b1_a_en_n(c1n), .b2_a_en_n(c2n), .sel(sel),
    .oe_a_n(oean), .oe_b_n(oebn)
  );

  function automatic logic [W-1:0] exp_a();
    return m_oea ? '0 : (m_sel ? m_c2 : m_c1);
  endfunction
  function automatic logic [W-1:0] exp_b1();
    return m_oeb ? '0 : m_s2;
  endfunction
  function automatic logic [W-1:0] exp_b2();
    return m_oeb ? '0 : m_hi;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    s1n = 1; s2n = 1; hin = 1; c1n = 1; c2n = 1;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_hi = '0; m_c1 = '0; m_c2 = '0;
      m_oea = 1; m_oeb = 1; m_sel = 0;
    end else begin
      if (!s2n) m_s2 = m_s1;
      if (!s1n) m_s1 = a_in;
      if (!hin) m_hi = a_in;
      if (!c1n) m_c1 = b1_in;
      if (!c2n) m_c2 = b2_in;
      m_oea = oean; m_oeb = oebn; m_sel = sel;
    end
    #1;
    check({tag, " a_out"},  a_out,  exp_a());
    check({tag, " b1_out"}, b1_out, exp_b1());
    check({tag, " b2_out"}, b2_out, exp_b2());
    check({tag, " a_drv"},  W'(a_drv),  W'(!m_oea));
    check({tag, " b1_drv"}, W'(b1_drv), W'(!m_oeb));
    check({tag, " b2_drv"}, W'(b2_drv), W'(!m_oeb));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w0, w1, keep1, keep2, keepa;
    void'($urandom(32'd7731));
    rst = 1; idle(); sel = 0; oean = 0; oebn = 0;
    a_in = 12'hABC; b1_in = 12'h123; b2_in = 12'h456;
    #1;
    tick("R9 reset");
    tick("R9 reset");
    check("R9 reset a_drv", W'(a_drv), '0);
    check("R9 reset b1_out", b1_out, '0);
    rst = 0;
    tick("R7 enable");

    w0 = 12'h5A1; w1 = 12'hC3E;
    a_in = w0; s1n = 0;
    tick("R2 word0");
    idle(); a_in = w1; s2n = 0; hin = 0;
    tick("R3 word1");
    check("R4 pair", b2_out, w1);
    check("R4 pair", b1_out, w0);
    idle();

    keep1 = b1_out; keep2 = b2_out;
    a_in = 12'hFFF; b1_in = 12'h0F0; b2_in = 12'h0E0;
    tick("R1 hold");
    check("R1 hold b1", b1_out, keep1);
    check("R1 hold b2", b2_out, keep2);

    b1_in = 12'h111; b2_in = 12'h222; c1n = 0; c2n = 0; sel = 0;
    tick("R5 capture");
    check("R6 sel0", a_out, 12'h111);
    idle(); sel = 1;
    tick("R6 sel1");
    check("R6 sel1", a_out, 12'h222);
    keepa = a_out;
    b2_in = 12'h999;
    tick("R1 hold cap");
    check("R1 hold cap", a_out, keepa);

    oean = 1; oebn = 1;
    tick("R8 off");
    check("R8 a_out off", a_out, '0);
    check("R8 b2_out off", b2_out, '0);
    check("R7 b1_drv off", W'(b1_drv), '0);
    oean = 0; oebn = 0;
    tick("R7 on");

    for (int i = 0; i < 400; i++) begin
      a_in = W'($urandom); b1_in = W'($urandom); b2_in = W'($urandom);
      s1n = $urandom_range(0, 1) == 1; s2n = $urandom_range(0, 1) == 1;
      hin = $urandom_range(0, 1) == 1; c1n = $urandom_range(0, 1) == 1;
      c2n = $urandom_range(0, 1) == 1; sel = $urandom_range(0, 1) == 1;
      oean = $urandom_range(0, 3) == 0; oebn = $urandom_range(0, 3) == 0;
      rst = $urandom_range(0, 63) == 0;
      tick(rst ? "R9 random" : "R2 R3 R5 R6 random");
    end

    rst = 1;
    tick("R9 final");
    check("R9 final a_drv", W'(a_drv), '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule